// File: doc/BRIEF.md
# Fixed-Point Frequency Tuning Multiplier

This block turns an output frequency, given as an unsigned integer number of hertz, into the phase increment that a direct digital synthesiser accumulates every sample clock. The conversion is a single multiplication by a scale constant. The constant holds the tuning-word change per hertz in 8.24 fixed point: 8 integer bits on top, 24 fraction bits below. Its value is 2^32 divided by the synthesiser reference clock in hertz. For example, a 125 MHz reference gives 0x225C17D0, a 100 MHz reference gives 0x2AF31DC4 and a 180 MHz reference gives 0x17DC65DE. The block keeps only the integer part of the product, so the fraction is dropped with no rounding.

The multiplication is sequential. A one-cycle start pulse captures both operands and clears a 40-bit accumulator. One scale bit is then consumed per clock, starting from the least significant bit. When the bit is set, the frequency is added into the accumulator 8 bits above its lowest bit, and any carry out of the top is lost. The accumulator and the scale are then shifted right by one. After 32 such steps, the lower 32 accumulator bits are the tuning word, and a one-cycle done pulse marks the result.

Top module: `freq_tuning_mul`

## Requirements
- R1: After reset, done_o is 0 and word_o is 0.
- R2: A cycle with start_i high captures freq_i and scale_i and clears the accumulator, so word_o reads 0 in the following cycle.
- R3: done_o goes high for exactly one cycle, in the cycle after the 33rd rising clock edge counted from the edge that sampled start_i (one load edge plus 32 iteration edges).
- R4: For freq_i below 2^31, the result on word_o when done_o is high equals floor(freq_i * scale_i / 2^24) mod 2^32, where scale_i is 8.24 fixed point (bits 31:24 integer, bits 23:0 fraction).
- R5: freq_i and scale_i are sampled only in the start cycle; changing them during a calculation does not change its result.
- R6: word_o holds its result, unchanged, from the done cycle until the next start_i.
- R7: start_i during a calculation abandons it: no done_o pulse comes from the abandoned run, and the new run completes with its own timing (R3) and result (R4).
- R8: The fraction is truncated with no rounding: scale 0x00000001 gives 0 for frequency 0x00FFFFFF and 1 for frequency 0x01000000; scale 0x01000000 returns the frequency unchanged; scale 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; loads operands and (re)starts a conversion |
| freq_i | input | 32 | Output frequency in hertz, unsigned |
| scale_i | input | 32 | Tuning-word change per hertz, 8.24 fixed point |
| done_o | output | 1 | One-cycle pulse when word_o holds a new result |
| word_o | output | 32 | Phase increment: integer part of freq_i * scale_i / 2^24 |

## Verification
The assertions take for granted that every frequency presented with start_i has its top bit clear. That keeps the accumulator, which peaks just under twice the frequency shifted up by 8 bits, from ever carrying out of its top bit, so the dropped carry never reaches the integer result. The directed stimulus holds every frequency at or below 0x7FFFFFFF, including the extreme case paired with an all-ones scale. Start pulses are driven one cycle at a time, including one that lands in the middle of a running calculation.

// File: rtl/ftm_pkg.sv
package ftm_pkg;

    // Sequencer phase of the multiplier.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } ftm_phase_e;

endpackage

// File: rtl/ftm_step.sv
// One add-and-shift iteration: optionally adds the multiplicand into the
// upper part of the accumulator (carry lost), then shifts right by one.
module ftm_step #(
    parameter int FREQ_W = 32,
    parameter int INT_W  = 8,
    localparam int ACC_W = FREQ_W + INT_W
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [FREQ_W-1:0] mcand_i,
    input  logic              add_en_i,
    output logic [ACC_W-1:0]  acc_o
);

    logic [FREQ_W-1:0] upper_sum;
    logic [ACC_W-1:0]  joined;

    always_comb begin
        // Width of the sum equals the upper slice, so the carry is dropped.
        upper_sum = acc_i[ACC_W-1:INT_W] + (add_en_i ? mcand_i : '0);
        joined    = {upper_sum, acc_i[INT_W-1:0]};
        acc_o     = joined >> 1;
    end

endmodule

// File: rtl/ftm_seq.sv
// Iteration sequencer: counts the multiplier bits and issues the done pulse.
module ftm_seq
    import ftm_pkg::*;
#(
    parameter int ITERS = 32,
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic step_o,
    output logic done_o
);

    typedef struct packed {
        ftm_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_RUN) begin
            if (st_q.cnt == CNT_W'(ITERS - 1)) begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
                st_d.done  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = (st_q.phase == PH_RUN) && !start_i;
    assign done_o = st_q.done;

endmodule

// File: rtl/freq_tuning_mul.sv
// Sequential frequency-to-phase-increment multiplier, scale in fixed point.
module freq_tuning_mul #(
    parameter int FREQ_W  = 32,
    parameter int SCALE_W = 32,
    parameter int FRAC_W  = 24,
    localparam int INT_W  = SCALE_W - FRAC_W,
    localparam int ACC_W  = FREQ_W + INT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic              done_o,
    output logic [FREQ_W-1:0] word_o
);

    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [FREQ_W-1:0]  mcand;
        logic [SCALE_W-1:0] mplier;
    } dp_state_t;

    dp_state_t dp_d, dp_q;
    logic             step_en;
    logic [ACC_W-1:0] acc_next;

    ftm_seq #(
        .ITERS(SCALE_W)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .step_o (step_en),
        .done_o (done_o)
    );

    ftm_step #(
        .FREQ_W(FREQ_W),
        .INT_W (INT_W)
    ) step_i (
        .acc_i   (dp_q.acc),
        .mcand_i (dp_q.mcand),
        .add_en_i(dp_q.mplier[0]),
        .acc_o   (acc_next)
    );

    always_comb begin
        dp_d = dp_q;
        if (start_i) begin
            dp_d.acc    = '0;
            dp_d.mcand  = freq_i;
            dp_d.mplier = scale_i;
        end else if (step_en) begin
            dp_d.acc    = acc_next;
            dp_d.mplier = dp_q.mplier >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign word_o = dp_q.acc[FREQ_W-1:0];

endmodule

// File: rtl/ftm_checker.sv
module ftm_checker #(
    parameter int FREQ_W  = 32,
    parameter int SCALE_W = 32,
    localparam int SINCE_W = $clog2(SCALE_W + 3)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [FREQ_W-1:0] freq_i,
    input logic              done_o,
    input logic [FREQ_W-1:0] word_o
);

    // Edges seen since the edge that sampled start; 0 = no start yet.
    logic [SINCE_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (start_i) begin
            since_q <= SINCE_W'(1);
        end else if (since_q != '0 && since_q < SINCE_W'(SCALE_W + 2)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // Input precondition: frequency top bit clear, so no carry is lost (R4).
    p_freq_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !freq_i[FREQ_W-1]);

    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (word_o == '0));

    p_done_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_q == SINCE_W'(SCALE_W + 1)));

    p_done_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == SINCE_W'(SCALE_W + 1)) |-> done_o);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(word_o));

endmodule

bind freq_tuning_mul ftm_checker #(
    .FREQ_W (FREQ_W),
    .SCALE_W(SCALE_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .freq_i (freq_i),
    .done_o (done_o),
    .word_o (word_o)
);

// File: tb/freq_tuning_mul_tb.sv
module freq_tuning_mul_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] freq_i = '0;
    logic [31:0] scale_i = '0;
    logic        done_o;
    logic [31:0] word_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    freq_tuning_mul dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .freq_i (freq_i),
        .scale_i(scale_i),
        .done_o (done_o),
        .word_o (word_o)
    );

    function automatic logic [31:0] expect_word(input logic [31:0] f, input logic [31:0] k);
        logic [63:0] p;
        p = 64'(f) * 64'(k);
        return p[55:24];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Pulse start, optionally disturb inputs during the run, verify timing and result.
    task automatic run_mul(input logic [31:0] f, input logic [31:0] k, input bit disturb);
        int cycles;
        logic [31:0] held;
        @(negedge clk);
        freq_i  = f;
        scale_i = k;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(word_o == 32'h0, "R2", word_o, 32'h0);
        if (disturb) begin
            freq_i  = ~f >> 1;
            scale_i = ~k;
        end
        cycles = 1;
        while (!done_o && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
        check(cycles == 33, "R3", 32'(cycles), 32'd33);
        check(word_o == expect_word(f, k), disturb ? "R5" : "R4", word_o, expect_word(f, k));
        held = word_o;
        @(negedge clk);
        check(!done_o, "R3", 32'(done_o), 32'd0);
        repeat (4) @(negedge clk);
        check(word_o == held, "R6", word_o, held);
    endtask

    task automatic t_reset;
        check(done_o == 1'b0, "R1", 32'(done_o), 32'd0);
        check(word_o == 32'h0, "R1", word_o, 32'h0);
    endtask

    task automatic t_examples;
        run_mul(32'd7030000, 32'h225C17D0, 1'b0);   // R4, 125 MHz reference
        run_mul(32'd14250000, 32'h17DC65DE, 1'b0);  // R4, 180 MHz reference
        run_mul(32'd3500000, 32'h2AF31DC4, 1'b0);   // R4, 100 MHz reference
        run_mul(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0);  // R4, largest allowed operands
    endtask

    task automatic t_truncation;
        run_mul(32'h00FFFFFF, 32'h00000001, 1'b0);  // R8: fraction dropped -> 0
        run_mul(32'h01000000, 32'h00000001, 1'b0);  // R8: exactly 1
        run_mul(32'd123456,   32'h01000000, 1'b0);  // R8: unit scale
        run_mul(32'd987654,   32'h00000000, 1'b0);  // R8: zero scale
        check(word_o == 32'h0, "R8", word_o, 32'h0);
    endtask

    task automatic t_sampling;
        run_mul(32'd28074000, 32'h225C17D0, 1'b1);  // R5
    endtask

    task automatic t_restart;
        int cycles;
        bit early;
        logic [31:0] exp_b;
        exp_b = expect_word(32'd10100000, 32'h2AF31DC4);
        @(negedge clk);
        freq_i  = 32'd7000000;
        scale_i = 32'h225C17D0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        early = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (done_o) early = 1'b1;
        end
        freq_i  = 32'd10100000;
        scale_i = 32'h2AF31DC4;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 1;
        while (!done_o && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
        check(!early, "R7", 32'(early), 32'd0);
        check(cycles == 33, "R7", 32'(cycles), 32'd33);
        check(word_o == exp_b, "R7", word_o, exp_b);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_truncation();
        t_sampling();
        t_restart();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule